// File: doc/BRIEF.md
# Timer Control Register with User-Level Access Trapping

This block holds the 32-bit control word that a kernel uses to govern how user code (privilege level 0) may touch the timer and counter registers. It also stores the settings for a counter-derived event stream, though it does not generate that stream. Privileged code (levels 1 to 3) reads and writes the word through a single-cycle port. Any attempt by user code to read or write the word is flagged as an undefined instruction, and such a write leaves the word unchanged.

Alongside the storage sits combinational trap logic. The core presents the current privilege level and a code naming the timer or counter register an instruction is about to touch. The block answers in the same cycle with one flag per register class, telling the core whether the access must be diverted to the undefined-instruction handler. Reserved bit positions are not stored and always read as zero. The scale bit (bit 17) is stored only when the `HAS_SCALE` parameter is set; otherwise it behaves as reserved. Reset loads the parameter `RST_VAL`, masked to the implemented bits, so that simulation is deterministic.

Top module: `tmr_ctl_top`

## Requirements
- R1: After reset the word holds `RST_VAL` masked to the implemented bits. The implemented bits are 17 (only when `HAS_SCALE`=1) and 9:0.
- R2: A write (`req_i`=1, `we_i`=1) at level 1, 2 or 3 stores `wdata_i` masked to the implemented bits at the clock edge. A read (`req_i`=1, `we_i`=0) at level 1 to 3 returns the stored word on `rdata_o` combinationally. `rdata_o` is 0 whenever no legal read is presented.
- R3: Bits 31:18 and 16:10 ignore writes and always read 0. Bit 17 is writable and readable when `HAS_SCALE`=1.
- R4: Any request at level 0 (`el_i`=0) raises `undef_o` in the same cycle, and `rdata_o` stays 0. `undef_o` is 0 at every other level and whenever `req_i`=0.
- R5: A write flagged by `undef_o` leaves the stored word unchanged.
- R6: At level 0, target codes 1, 2 and 3 (physical timer control, compare value, timer value) raise `trap_o[3]` when bit 9 is 0.
- R7: At level 0, target codes 4, 5 and 6 (virtual timer control, compare value, timer value) raise `trap_o[4]` when bit 8 is 0.
- R8: At level 0, target code 7 (physical counter) raises `trap_o[0]` when bit 0 is 0. Target code 8 (virtual counter) raises `trap_o[1]` when bit 1 is 0.
- R9: At level 0, target code 9 (counter frequency) raises `trap_o[2]` only when bits 0 and 1 are both 0.
- R10: `trap_o` is all zeros at levels 1 to 3, for code 0 (no access) and for codes 10 to 15. At most one bit of `trap_o` is ever set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| el_i | input | 2 | Current privilege level, 0 = user |
| req_i | input | 1 | Access request to the control word |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data |
| tgt_i | input | 4 | Code of the timer/counter register being accessed, 0 = none |
| rdata_o | output | 32 | Read data, 0 when no legal read |
| undef_o | output | 1 | Undefined-instruction flag for control-word access |
| trap_o | output | 5 | Trap flags: [0] phys counter, [1] virt counter, [2] frequency, [3] phys timer, [4] virt timer |

## Verification
The read data, the undefined flag and the trap flags are combinational, so each is due in the cycle its stimulus is applied. A write becomes visible only from the cycle after the clock edge that samples it. The driver applies each stimulus just after a rising edge and queues the expected outputs, computed from a bench copy of the word. The monitor compares them at the following falling edge. The bench copy takes the effect of a write only after it has computed that cycle's expectation, so every read that follows a write checks the one-cycle latency.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;

    localparam int CTL_W   = 32;
    localparam int TGT_W   = 4;
    localparam int NTRAP   = 5;

    // Bit positions decoded by the trap logic
    localparam int POS_SCALE = 17;
    localparam int POS_PTEN  = 9;
    localparam int POS_VTEN  = 8;
    localparam int POS_VCEN  = 1;
    localparam int POS_PCEN  = 0;
    localparam int LOW_BITS  = 10;

    // Trap vector positions
    localparam int TRP_PCNT  = 0;
    localparam int TRP_VCNT  = 1;
    localparam int TRP_FREQ  = 2;
    localparam int TRP_PTMR  = 3;
    localparam int TRP_VTMR  = 4;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } lvl_e;

    typedef enum logic [TGT_W-1:0] {
        TGT_NONE    = 4'd0,
        TGT_PT_CTL  = 4'd1,
        TGT_PT_CMP  = 4'd2,
        TGT_PT_TV   = 4'd3,
        TGT_VT_CTL  = 4'd4,
        TGT_VT_CMP  = 4'd5,
        TGT_VT_TV   = 4'd6,
        TGT_PCNT    = 4'd7,
        TGT_VCNT    = 4'd8,
        TGT_FREQ    = 4'd9
    } tgt_e;

    function automatic logic [CTL_W-1:0] impl_mask(input bit has_scale);
        logic [CTL_W-1:0] m;
        m = '0;
        for (int i = 0; i < LOW_BITS; i++) m[i] = 1'b1;
        m[POS_SCALE] = has_scale;
        return m;
    endfunction

endpackage

// File: rtl/tmr_ctl_access.sv
module tmr_ctl_access
    import tmr_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] el_i,
    input  logic       req_i,
    input  logic       we_i,
    output logic       undef_o,
    output logic       wr_en_o,
    output logic       rd_en_o
);

    lvl_e lvl;
    logic priv;

    always_comb begin
        lvl = lvl_e'(el_i);
        unique case (lvl)
            LVL_USER: priv = 1'b0;
            LVL_KERN,
            LVL_HYP,
            LVL_MON:  priv = 1'b1;
            default:  priv = 1'b0;
        endcase
    end

    always_comb begin
        undef_o = req_i && !priv;
        wr_en_o = req_i &&  priv &&  we_i;
        rd_en_o = req_i &&  priv && !we_i;
    end

    AST_UNDEF_ONLY_USER: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> (el_i == 2'd0)); // R4
    AST_NO_PRIV_PATH_IN_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (el_i == 2'd0) |-> !(wr_en_o || rd_en_o)); // R5

endmodule

// File: rtl/tmr_ctl_store.sv
module tmr_ctl_store
    import tmr_ctl_pkg::*;
#(
    parameter logic [CTL_W-1:0] RST_VAL   = '0,
    parameter bit               HAS_SCALE = 1'b1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wdata_i,
    output logic [CTL_W-1:0] ctl_o
);

    localparam logic [CTL_W-1:0] WMASK = impl_mask(HAS_SCALE);

    for (genvar b = 0; b < CTL_W; b++) begin : g_bit
        if (WMASK[b]) begin : g_flop
            logic q;
            always_ff @(posedge clk) begin
                if (!rst_n)       q <= RST_VAL[b];
                else if (wr_en_i) q <= wdata_i[b];
            end
            assign ctl_o[b] = q;
        end else begin : g_zero
            assign ctl_o[b] = 1'b0;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (ctl_o == ($past(wdata_i) & WMASK))); // R2
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o & ~WMASK) == '0); // R3
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(ctl_o)); // R5

endmodule

// File: rtl/tmr_ctl_trap.sv
module tmr_ctl_trap
    import tmr_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       el_i,
    input  logic [TGT_W-1:0] tgt_i,
    input  logic             pt_en_i,
    input  logic             vt_en_i,
    input  logic             pc_en_i,
    input  logic             vc_en_i,
    output logic [NTRAP-1:0] trap_o
);

    tgt_e tgt;
    logic [NTRAP-1:0] raw;

    always_comb begin
        tgt = tgt_e'(tgt_i);
        raw = '0;
        unique case (tgt)
            TGT_PT_CTL, TGT_PT_CMP, TGT_PT_TV: raw[TRP_PTMR] = !pt_en_i;
            TGT_VT_CTL, TGT_VT_CMP, TGT_VT_TV: raw[TRP_VTMR] = !vt_en_i;
            TGT_PCNT:  raw[TRP_PCNT] = !pc_en_i;
            TGT_VCNT:  raw[TRP_VCNT] = !vc_en_i;
            TGT_FREQ:  raw[TRP_FREQ] = !pc_en_i && !vc_en_i;
            TGT_NONE:  raw = '0;
            default:   raw = '0;
        endcase
    end

    always_comb trap_o = (el_i == 2'd0) ? raw : '0;

    AST_TRAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trap_o)); // R10
    AST_NO_TRAP_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (el_i != 2'd0) |-> (trap_o == '0)); // R10
    AST_FREQ_BOTH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o[TRP_FREQ] |-> (!pc_en_i && !vc_en_i)); // R9

endmodule

// File: rtl/tmr_ctl_top.sv
module tmr_ctl_top
    import tmr_ctl_pkg::*;
#(
    parameter logic [31:0] RST_VAL   = 32'h0000_0303,
    parameter bit          HAS_SCALE = 1'b1
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  el_i,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [31:0] wdata_i,
    input  logic [3:0]  tgt_i,
    output logic [31:0] rdata_o,
    output logic        undef_o,
    output logic [4:0]  trap_o
);

    logic             wr_en, rd_en;
    logic [CTL_W-1:0] ctl_q;

    tmr_ctl_access u_access (
        .clk     (clk),
        .rst_n   (rst_n),
        .el_i    (el_i),
        .req_i   (req_i),
        .we_i    (we_i),
        .undef_o (undef_o),
        .wr_en_o (wr_en),
        .rd_en_o (rd_en)
    );

    tmr_ctl_store #(
        .RST_VAL   (RST_VAL),
        .HAS_SCALE (HAS_SCALE)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .wdata_i (wdata_i),
        .ctl_o   (ctl_q)
    );

    tmr_ctl_trap u_trap (
        .clk     (clk),
        .rst_n   (rst_n),
        .el_i    (el_i),
        .tgt_i   (tgt_i),
        .pt_en_i (ctl_q[POS_PTEN]),
        .vt_en_i (ctl_q[POS_VTEN]),
        .pc_en_i (ctl_q[POS_PCEN]),
        .vc_en_i (ctl_q[POS_VCEN]),
        .trap_o  (trap_o)
    );

    always_comb rdata_o = rd_en ? ctl_q : '0;

    AST_UNDEF_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_o && we_i) |=> $stable(ctl_q)); // R5
    AST_USER_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> (rdata_o == '0)); // R4
    AST_PRIV_READ_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && el_i != 2'd0) |-> (rdata_o == ctl_q)); // R2

endmodule

// File: tb/sim_tmr_ctl_top.sv
module sim_tmr_ctl_top;

    localparam logic [31:0] RV    = 32'hA5A5_0303;
    localparam logic [31:0] IMASK = 32'h0002_03FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  el = 2'd1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [3:0]  tg = '0;
    logic [31:0] rdata;
    logic        undef;
    logic [4:0]  trap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model;

    logic [31:0] q_rd[$];
    logic        q_un[$];
    logic [4:0]  q_tr[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    tmr_ctl_top #(.RST_VAL(RV), .HAS_SCALE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .el_i(el), .req_i(req), .we_i(we),
        .wdata_i(wd), .tgt_i(tg), .rdata_o(rdata), .undef_o(undef), .trap_o(trap)
    );

    function automatic logic [4:0] exp_trap(input logic [1:0] l, input logic [3:0] t,
                                            input logic [31:0] m);
        logic [4:0] r;
        r = '0;
        if (l == 2'd0) begin
            if (t >= 4'd1 && t <= 4'd3) r[3] = !m[9];
            else if (t >= 4'd4 && t <= 4'd6) r[4] = !m[8];
            else if (t == 4'd7) r[0] = !m[0];
            else if (t == 4'd8) r[1] = !m[1];
            else if (t == 4'd9) r[2] = !m[0] && !m[1];
        end
        return r;
    endfunction

    task automatic drive(input logic [1:0] l, input logic rq, input logic w,
                         input logic [31:0] d, input logic [3:0] t, input string tag);
        @(posedge clk);
        #1;
        el = l; req = rq; we = w; wd = d; tg = t;
        q_rd.push_back((rq && !w && l != 2'd0) ? model : 32'h0);
        q_un.push_back(rq && l == 2'd0);
        q_tr.push_back(exp_trap(l, t, model));
        q_tag.push_back(tag);
        if (rq && w && l != 2'd0) model = d & IMASK;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (q_rd.size() > 0) begin
                logic [31:0] e_rd;
                logic        e_un;
                logic [4:0]  e_tr;
                string       tag;
                e_rd = q_rd.pop_front();
                e_un = q_un.pop_front();
                e_tr = q_tr.pop_front();
                tag  = q_tag.pop_front();
                checks++;
                if (rdata !== e_rd) begin
                    errors++;
                    $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, e_rd);
                end
                checks++;
                if (undef !== e_un) begin
                    errors++;
                    $display("FAIL %s undef actual=%b expected=%b", tag, undef, e_un);
                end
                checks++;
                if (trap !== e_tr) begin
                    errors++;
                    $display("FAIL %s trap actual=%b expected=%b", tag, trap, e_tr);
                end
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        model = RV & IMASK;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset value, reserved bits dropped
        drive(2'd1, 1'b1, 1'b0, '0, 4'd0, "R1");
        // R2 and R3: all-ones write, readback masked next cycle
        drive(2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF, 4'd0, "R2");
        drive(2'd3, 1'b1, 1'b0, '0, 4'd0, "R3");
        // R4: user-level read and write are undefined
        drive(2'd0, 1'b1, 1'b0, '0, 4'd0, "R4");
        drive(2'd0, 1'b1, 1'b1, 32'h0, 4'd0, "R4");
        // R5: the undefined write changed nothing
        drive(2'd1, 1'b1, 1'b0, '0, 4'd0, "R5");
        drive(2'd1, 1'b0, 1'b0, '0, 4'd0, "R2");
        // All enables clear: every user-level target traps
        drive(2'd1, 1'b1, 1'b1, 32'hFFFD_FC00, 4'd0, "R3");
        drive(2'd1, 1'b1, 1'b0, '0, 4'd0, "R3");
        for (int t = 0; t < 16; t++) drive(2'd0, 1'b0, 1'b0, '0, 4'(t), "R6/R7/R8/R9");
        for (int l = 1; l < 4; l++)
            for (int t = 0; t < 16; t++) drive(2'(l), 1'b0, 1'b0, '0, 4'(t), "R10");
        // R8 and R9: only physical counter enabled
        drive(2'd1, 1'b1, 1'b1, 32'h0000_0001, 4'd0, "R2");
        drive(2'd0, 1'b0, 1'b0, '0, 4'd7, "R8");
        drive(2'd0, 1'b0, 1'b0, '0, 4'd8, "R8");
        drive(2'd0, 1'b0, 1'b0, '0, 4'd9, "R9");
        // Only virtual counter enabled
        drive(2'd1, 1'b1, 1'b1, 32'h0000_0002, 4'd0, "R2");
        drive(2'd0, 1'b0, 1'b0, '0, 4'd7, "R8");
        drive(2'd0, 1'b0, 1'b0, '0, 4'd8, "R8");
        drive(2'd0, 1'b0, 1'b0, '0, 4'd9, "R9");
        // R6: physical timer enable only
        drive(2'd1, 1'b1, 1'b1, 32'h0000_0200, 4'd0, "R2");
        for (int t = 1; t < 7; t++) drive(2'd0, 1'b0, 1'b0, '0, 4'(t), "R6");
        drive(2'd0, 1'b0, 1'b0, '0, 4'd9, "R9");
        // R7: virtual timer enable only, plus scale bit kept
        drive(2'd1, 1'b1, 1'b1, 32'h0002_0100, 4'd0, "R2");
        for (int t = 1; t < 7; t++) drive(2'd0, 1'b0, 1'b0, '0, 4'(t), "R7");
        drive(2'd2, 1'b1, 1'b0, '0, 4'd0, "R3");
        // User request together with a trapped target
        drive(2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 4'd2, "R4");
        drive(2'd1, 1'b1, 1'b0, '0, 4'd0, "R5");
        drive(2'd1, 1'b0, 1'b0, '0, 4'd0, "R10");
        repeat (3) @(posedge clk);
        checks++;
        if (q_rd.size() != 0) begin
            errors++;
            $display("FAIL R2 queue actual=%0d expected=0", q_rd.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule